// File: doc/BRIEF.md
# Delayed Read Request Synchronizer

This block moves a single delayed read request from a bus-target clock domain into a bus-master clock domain, then carries the matching completion back. The target side raises a one-cycle strobe with the address, byte enables, bus command and a write flag. The block keeps that request in holding registers and returns the stored address and command to the target side. A retried access can then be compared against them to find out whether it is the same read. The master side sees a valid request that stays up until the master raises a completion strobe with a status bit.

On the target side, two flags show where the transaction stands. A request flag is up while the request is outstanding. A completion flag is up once the completion can be taken. A done strobe from the requester retires the completion. An in-progress level protects a completion that is being transferred. If a ready completion sits unclaimed for a full timeout window, the block pulses a flush output so the buffered data is dropped, and it returns to idle. Only one transaction exists at a time. Each crossing uses a toggle and a multi-flop synchronizer, and the data fields are held stable while their toggle is in flight.

Top module: `dlyrd_sync`

## Requirements
- R1: After either reset, the following are all 0: `t_req_pending`, `t_cmp_pending`, `t_cmp_flush`, `t_stored_addr`, `t_stored_cmd` and `m_req_valid`.
- R2: A strobe with the write flag at 0, taken while idle, sets `t_req_pending` at the next target edge. The master side then raises `m_req_valid` with the same address, byte enables and command and with `m_req_wr` = 0. All of these stay unchanged until `m_cmp_stb` is taken.
- R3: `t_stored_addr` and `t_stored_cmd` equal the accepted request's address and command, and they do not change while either pending flag is set.
- R4: A strobe that arrives while `t_req_pending` or `t_cmp_pending` is set is ignored. The stored fields and the master-side request are unchanged.
- R5: A strobe with the write flag at 1 (write request) is ignored: `t_req_pending` stays 0.
- R6: `m_cmp_stb` with `m_cmp_status` (0 = normal, 1 = error) clears `m_req_valid` at the next master edge. After the crossing, `t_req_pending` reads 0, `t_cmp_pending` reads 1 and `t_cmp_status` equals the given status.
- R7: `t_done` while `t_cmp_pending` is set clears `t_cmp_pending` at the next target edge, and no flush is raised.
- R8: Suppose `t_cmp_pending` stays set for 2^TMO_LOG2 target cycles (65536 by default) with neither `t_done` nor `t_in_progress`. Then, at that edge, `t_cmp_flush` pulses for exactly one cycle and `t_cmp_pending` clears.
- R9: While `t_in_progress` is high the timeout count is held at zero, so no flush occurs. A full window is counted again only after it drops.
- R10: `m_cmp_stb` while `m_req_valid` is 0 is ignored, and `t_cmp_pending` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tgt_clk | input | 1 | Target-domain clock |
| tgt_rst | input | 1 | Target-domain asynchronous reset, active high |
| t_req_stb | input | 1 | Request strobe qualifying the fields below |
| t_req_addr | input | AW | Request address |
| t_req_be | input | BEW | Request byte enables |
| t_req_cmd | input | CW | Request bus command |
| t_req_wr | input | 1 | 1 = write request, 0 = read request |
| t_done | input | 1 | Requester finished taking the completion |
| t_in_progress | input | 1 | Completion transfer under way |
| t_req_pending | output | 1 | Request outstanding |
| t_cmp_pending | output | 1 | Completion ready to be taken |
| t_cmp_status | output | 1 | Completion status, 1 = error |
| t_cmp_flush | output | 1 | One-cycle pulse: unclaimed completion discarded |
| t_stored_addr | output | AW | Address of the held request |
| t_stored_cmd | output | CW | Command of the held request |
| mst_clk | input | 1 | Master-domain clock |
| mst_rst | input | 1 | Master-domain asynchronous reset, active high |
| m_req_valid | output | 1 | Request valid on the master side |
| m_req_addr | output | AW | Request address, master side |
| m_req_be | output | BEW | Byte enables, master side |
| m_req_cmd | output | CW | Bus command, master side |
| m_req_wr | output | 1 | Write flag, master side |
| m_cmp_stb | input | 1 | Master completion strobe |
| m_cmp_status | input | 1 | Completion status, 1 = error |

## Verification
A target state stuck in the wrong place appears at once on the two pending flags: a second request is accepted, or a completion never retires, within one target cycle of the strobe or the done. A lost toggle edge leaves `m_req_valid` or `t_cmp_pending` low for good, which the bench catches within about twenty cycles of the other side's action. A timeout counter that is off by one or not cleared moves the flush pulse by a cycle, and the bench checks the exact edge at which it appears.

// File: rtl/dlyrd_pkg.sv
package dlyrd_pkg;
   // target-side transaction phase
   typedef enum logic [1:0] {
      TS_IDLE  = 2'd0,
      TS_WAIT  = 2'd1,
      TS_READY = 2'd2
   } tside_e;

   localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/dlyrd_tgl_rx.sv
// Receives a toggle from another domain and turns each change into a one-cycle pulse.
module dlyrd_tgl_rx #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic tgl_in,
   output logic pulse
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain <= '0;
            else     chain <= tgl_in;
         end
      end else begin : g_multi
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], tgl_in};
         end
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) last_q <= 1'b0;
      else     last_q <= chain[STAGES-1];
   end

   assign pulse = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/dlyrd_tgt_side.sv
module dlyrd_tgt_side
   import dlyrd_pkg::*;
#(
   parameter int AW       = 32,
   parameter int BEW      = 4,
   parameter int CW       = 4,
   parameter int TMO_LOG2 = 16
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           stb,
   input  logic [AW-1:0]  addr,
   input  logic [BEW-1:0] be,
   input  logic [CW-1:0]  cmd,
   input  logic           wr,
   input  logic           done,
   input  logic           inprog,
   input  logic           cmp_pulse,
   input  logic           cmp_status_x,
   output logic           req_tgl,
   output logic [AW-1:0]  hold_addr,
   output logic [BEW-1:0] hold_be,
   output logic [CW-1:0]  hold_cmd,
   output logic           hold_wr,
   output logic           req_pend,
   output logic           cmp_pend,
   output logic           cmp_status,
   output logic           flush
);
   localparam logic [TMO_LOG2-1:0] CNT_MAX = '1;

   tside_e              state;
   logic [TMO_LOG2-1:0] age;

   initial begin
      AST_TMO_WIDTH: assert (TMO_LOG2 >= 2 && TMO_LOG2 <= 31) else $error("TMO_LOG2 out of range");
      AST_FIELD_WIDTHS: assert (AW > 0 && BEW > 0 && CW > 0) else $error("field width zero");
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state      <= TS_IDLE;
         req_tgl    <= 1'b0;
         hold_addr  <= '0;
         hold_be    <= '0;
         hold_cmd   <= '0;
         hold_wr    <= 1'b0;
         cmp_status <= 1'b0;
         age        <= '0;
         flush      <= 1'b0;
      end else begin
         flush <= 1'b0;
         case (state)
            TS_IDLE: begin
               if (stb && !wr) begin
                  hold_addr <= addr;
                  hold_be   <= be;
                  hold_cmd  <= cmd;
                  hold_wr   <= wr;
                  req_tgl   <= ~req_tgl;
                  state     <= TS_WAIT;
               end
            end
            TS_WAIT: begin
               if (cmp_pulse) begin
                  cmp_status <= cmp_status_x;
                  age        <= '0;
                  state      <= TS_READY;
               end
            end
            TS_READY: begin
               if (done) begin
                  age   <= '0;
                  state <= TS_IDLE;
               end else if (inprog) begin
                  age <= '0;
               end else if (age == CNT_MAX) begin
                  age   <= '0;
                  flush <= 1'b1;
                  state <= TS_IDLE;
               end else begin
                  age <= age + 1'b1;
               end
            end
            default: state <= TS_IDLE;
         endcase
      end
   end

   assign req_pend = (state == TS_WAIT);
   assign cmp_pend = (state == TS_READY);

   AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (state == TS_IDLE && stb && wr) |=> (state == TS_IDLE)) else $error("write accepted"); // R5
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (state != TS_IDLE) |=> ($stable(hold_addr) && $stable(hold_cmd))) else $error("held fields moved"); // R3
   AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (rst)
      (state == TS_READY && done) |=> (state == TS_IDLE && !flush)) else $error("done ignored"); // R7
   AST_INPROG_GUARD: assert property (@(posedge clk) disable iff (rst)
      (state == TS_READY && inprog) |=> !flush) else $error("flush during transfer"); // R9
   AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (rst)
      flush |-> (state == TS_IDLE && $past(state) == TS_READY)) else $error("flush without ready"); // R8
   AST_AGE_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
      (age != '0) |-> (state == TS_READY)) else $error("timer running outside ready"); // R8
endmodule

// File: rtl/dlyrd_mst_side.sv
module dlyrd_mst_side #(
   parameter int AW  = 32,
   parameter int BEW = 4,
   parameter int CW  = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           req_pulse,
   input  logic [AW-1:0]  x_addr,
   input  logic [BEW-1:0] x_be,
   input  logic [CW-1:0]  x_cmd,
   input  logic           x_wr,
   input  logic           cmp_stb,
   input  logic           cmp_status_in,
   output logic           valid,
   output logic [AW-1:0]  addr,
   output logic [BEW-1:0] be,
   output logic [CW-1:0]  cmd,
   output logic           wr,
   output logic           cmp_tgl,
   output logic           cmp_status_q
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         valid        <= 1'b0;
         addr         <= '0;
         be           <= '0;
         cmd          <= '0;
         wr           <= 1'b0;
         cmp_tgl      <= 1'b0;
         cmp_status_q <= 1'b0;
      end else begin
         if (req_pulse) begin
            valid <= 1'b1;
            addr  <= x_addr;
            be    <= x_be;
            cmd   <= x_cmd;
            wr    <= x_wr;
         end else if (valid && cmp_stb) begin
            valid        <= 1'b0;
            cmp_status_q <= cmp_status_in;
            cmp_tgl      <= ~cmp_tgl;
         end
      end
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
      (valid && !cmp_stb) |=> (valid && $stable(addr) && $stable(cmd) && $stable(be))) else $error("request dropped"); // R2
   AST_STRAY_CMP: assert property (@(posedge clk) disable iff (rst)
      (!valid && !req_pulse && cmp_stb) |=> $stable(cmp_tgl)) else $error("stray completion sent"); // R10
   AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (valid && cmp_stb && !req_pulse) |=> !valid) else $error("completion did not clear"); // R6
endmodule

// File: rtl/dlyrd_sync.sv
module dlyrd_sync
   import dlyrd_pkg::*;
#(
   parameter int AW          = 32,
   parameter int BEW         = 4,
   parameter int CW          = 4,
   parameter int SYNC_STAGES = 2,
   parameter int TMO_LOG2    = 16
) (
   input  logic           tgt_clk,
   input  logic           tgt_rst,
   input  logic           t_req_stb,
   input  logic [AW-1:0]  t_req_addr,
   input  logic [BEW-1:0] t_req_be,
   input  logic [CW-1:0]  t_req_cmd,
   input  logic           t_req_wr,
   input  logic           t_done,
   input  logic           t_in_progress,
   output logic           t_req_pending,
   output logic           t_cmp_pending,
   output logic           t_cmp_status,
   output logic           t_cmp_flush,
   output logic [AW-1:0]  t_stored_addr,
   output logic [CW-1:0]  t_stored_cmd,
   input  logic           mst_clk,
   input  logic           mst_rst,
   output logic           m_req_valid,
   output logic [AW-1:0]  m_req_addr,
   output logic [BEW-1:0] m_req_be,
   output logic [CW-1:0]  m_req_cmd,
   output logic           m_req_wr,
   input  logic           m_cmp_stb,
   input  logic           m_cmp_status
);
   logic           req_tgl, cmp_tgl;
   logic           req_pulse_m, cmp_pulse_t;
   logic [BEW-1:0] hold_be;
   logic           hold_wr;
   logic           cmp_status_m;

   initial begin
      AST_SYNC_DEPTH: assert (SYNC_STAGES >= MIN_SYNC_STAGES) else $error("too few sync stages");
   end

   dlyrd_tgt_side #(.AW(AW), .BEW(BEW), .CW(CW), .TMO_LOG2(TMO_LOG2)) u_tgt (
      .clk(tgt_clk), .rst(tgt_rst),
      .stb(t_req_stb), .addr(t_req_addr), .be(t_req_be), .cmd(t_req_cmd), .wr(t_req_wr),
      .done(t_done), .inprog(t_in_progress),
      .cmp_pulse(cmp_pulse_t), .cmp_status_x(cmp_status_m),
      .req_tgl(req_tgl), .hold_addr(t_stored_addr), .hold_be(hold_be),
      .hold_cmd(t_stored_cmd), .hold_wr(hold_wr),
      .req_pend(t_req_pending), .cmp_pend(t_cmp_pending),
      .cmp_status(t_cmp_status), .flush(t_cmp_flush)
   );

   dlyrd_tgl_rx #(.STAGES(SYNC_STAGES)) u_req_rx (
      .clk(mst_clk), .rst(mst_rst), .tgl_in(req_tgl), .pulse(req_pulse_m)
   );

   dlyrd_tgl_rx #(.STAGES(SYNC_STAGES)) u_cmp_rx (
      .clk(tgt_clk), .rst(tgt_rst), .tgl_in(cmp_tgl), .pulse(cmp_pulse_t)
   );

   dlyrd_mst_side #(.AW(AW), .BEW(BEW), .CW(CW)) u_mst (
      .clk(mst_clk), .rst(mst_rst), .req_pulse(req_pulse_m),
      .x_addr(t_stored_addr), .x_be(hold_be), .x_cmd(t_stored_cmd), .x_wr(hold_wr),
      .cmp_stb(m_cmp_stb), .cmp_status_in(m_cmp_status),
      .valid(m_req_valid), .addr(m_req_addr), .be(m_req_be), .cmd(m_req_cmd), .wr(m_req_wr),
      .cmp_tgl(cmp_tgl), .cmp_status_q(cmp_status_m)
   );

   AST_ONE_AT_A_TIME: assert property (@(posedge tgt_clk) disable iff (tgt_rst)
      (t_req_pending && t_req_stb) |=> $stable(t_stored_addr)) else $error("second request taken"); // R4
endmodule

// File: tb/dlyrd_sync_bench.sv
module dlyrd_sync_bench;
   localparam int AW = 32, BEW = 4, CW = 4;
   localparam int WINDOW = 65536;

   logic tgt_clk = 0, mst_clk = 0, tgt_rst = 1, mst_rst = 1;
   logic t_req_stb = 0, t_req_wr = 0, t_done = 0, t_in_progress = 0;
   logic [AW-1:0] t_req_addr = '0;
   logic [BEW-1:0] t_req_be = '0;
   logic [CW-1:0] t_req_cmd = '0;
   logic t_req_pending, t_cmp_pending, t_cmp_status, t_cmp_flush;
   logic [AW-1:0] t_stored_addr;
   logic [CW-1:0] t_stored_cmd;
   logic m_req_valid, m_req_wr;
   logic [AW-1:0] m_req_addr;
   logic [BEW-1:0] m_req_be;
   logic [CW-1:0] m_req_cmd;
   logic m_cmp_stb = 0, m_cmp_status = 0;

   int n_chk = 0, n_bad = 0, flush_seen = 0;

   always #5 tgt_clk = ~tgt_clk;
   always #7 mst_clk = ~mst_clk;

   dlyrd_sync u_dlyrd_sync (.*);

   always @(posedge tgt_clk) if (!tgt_rst && t_cmp_flush) flush_seen++;

   function automatic bit exp_accept(bit rp, bit cp, bit wr);
      return !rp && !cp && !wr;
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic strobe(logic [AW-1:0] a, logic [BEW-1:0] b, logic [CW-1:0] c, logic w);
      @(negedge tgt_clk);
      t_req_stb = 1; t_req_addr = a; t_req_be = b; t_req_cmd = c; t_req_wr = w;
      @(negedge tgt_clk);
      t_req_stb = 0; t_req_wr = 0;
   endtask

   task automatic wait_mvalid(output bit got);
      got = 0;
      for (int i = 0; i < 20 && !got; i++) begin
         @(negedge mst_clk);
         got = m_req_valid;
      end
   endtask

   task automatic wait_cmp(output bit got);
      got = 0;
      for (int i = 0; i < 30 && !got; i++) begin
         @(negedge tgt_clk);
         got = t_cmp_pending;
      end
   endtask

   task automatic complete(bit st);
      @(negedge mst_clk);
      m_cmp_stb = 1; m_cmp_status = st;
      @(negedge mst_clk);
      m_cmp_stb = 0;
      chk(m_req_valid == 0, "R6 valid drop", m_req_valid, 0);
   endtask

   // full read transaction with checks; extra = poke strobes while pending
   task automatic txn(logic [AW-1:0] a, logic [BEW-1:0] b, logic [CW-1:0] c, bit st, bit extra);
      bit got;
      strobe(a, b, c, 0);
      chk(t_req_pending == exp_accept(0, 0, 0), "R2 req pending", t_req_pending, 1);
      chk(t_stored_addr == a && t_stored_cmd == c, "R3 stored", t_stored_addr, a);
      if (extra) begin
         strobe(~a, ~b, ~c, 0);
         chk(t_stored_addr == a && t_stored_cmd == c, "R4 during request", t_stored_addr, a);
      end
      wait_mvalid(got);
      chk(got && m_req_addr == a && m_req_be == b && m_req_cmd == c && m_req_wr == 0,
          "R2 master fields", m_req_addr, a);
      complete(st);
      wait_cmp(got);
      chk(got && t_req_pending == 0 && t_cmp_status == st, "R6 completion",
          {got, t_req_pending, t_cmp_status}, {1'b1, 1'b0, st});
      if (extra) begin
         strobe(a ^ 32'h10, b, c, 0);
         chk(t_stored_addr == a && t_cmp_pending == 1 && t_req_pending == 0,
             "R4 during completion", t_stored_addr, a);
         repeat (6) @(negedge mst_clk);
         chk(m_req_valid == 0, "R4 no master request", m_req_valid, 0);
      end
      @(negedge tgt_clk); t_done = 1;
      @(negedge tgt_clk); t_done = 0;
      chk(t_cmp_pending == 0 && t_cmp_flush == 0, "R7 done retires", t_cmp_pending, 0);
   endtask

   initial begin
      repeat (195000) @(posedge tgt_clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      bit got;
      int f0;
      void'($urandom(32'h1d2c3b4a));
      repeat (3) @(negedge tgt_clk);
      chk(t_req_pending == 0 && t_cmp_pending == 0 && t_cmp_flush == 0 && t_stored_addr == 0
          && t_stored_cmd == 0 && m_req_valid == 0, "R1 in reset", t_req_pending, 0);
      tgt_rst = 0; mst_rst = 0;
      repeat (2) @(negedge tgt_clk);
      chk(t_req_pending == 0 && t_cmp_pending == 0 && m_req_valid == 0, "R1 after reset",
          m_req_valid, 0);

      // R10: stray completion
      complete(1);
      repeat (10) @(negedge tgt_clk);
      chk(t_cmp_pending == 0, "R10 stray completion", t_cmp_pending, 0);

      // R5: write request ignored
      strobe(32'hDEAD_BEEF, 4'h3, 4'h7, 1);
      chk(t_req_pending == exp_accept(0, 0, 1), "R5 write ignored", t_req_pending, 0);

      // directed corners
      txn(32'hFFFF_FFFF, 4'hF, 4'hF, 1, 1);
      txn(32'h0000_0000, 4'h0, 4'h6, 0, 0);

      // random mix
      for (int k = 0; k < 40; k++) begin
         logic [AW-1:0] a = $urandom;
         logic [BEW-1:0] b = BEW'($urandom);
         logic [CW-1:0] c = CW'($urandom);
         if (($urandom % 4) == 0) begin
            strobe(a, b, c, 1);
            chk(t_req_pending == exp_accept(0, 0, 1), "R5 random write", t_req_pending, 0);
         end else begin
            txn(a, b, c, 1'($urandom), 1'($urandom));
         end
      end

      // R8: exact timeout edge
      f0 = flush_seen;
      strobe(32'h1234_5678, 4'h1, 4'h6, 0);
      wait_mvalid(got);
      complete(0);
      wait_cmp(got);
      repeat (WINDOW - 1) @(negedge tgt_clk);
      chk(t_cmp_pending == 1 && t_cmp_flush == 0, "R8 before expiry", t_cmp_pending, 1);
      @(negedge tgt_clk);
      chk(t_cmp_flush == 1 && t_cmp_pending == 0, "R8 flush edge",
          {t_cmp_flush, t_cmp_pending}, 2'b10);
      @(negedge tgt_clk);
      chk(t_cmp_flush == 0 && flush_seen == f0 + 1, "R8 single pulse", flush_seen - f0, 1);

      // R9: in-progress restarts the window
      f0 = flush_seen;
      strobe(32'h0BAD_F00D, 4'h2, 4'hC, 0);
      wait_mvalid(got);
      complete(1);
      wait_cmp(got);
      repeat (WINDOW - 600) @(negedge tgt_clk);
      t_in_progress = 1;
      repeat (10) @(negedge tgt_clk);
      t_in_progress = 0;
      repeat (1000) @(negedge tgt_clk);
      chk(t_cmp_pending == 1 && flush_seen == f0, "R9 no flush after transfer",
          flush_seen - f0, 0);
      @(negedge tgt_clk); t_done = 1;
      @(negedge tgt_clk); t_done = 0;
      chk(t_cmp_pending == 0 && flush_seen == f0, "R7 done after transfer", t_cmp_pending, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule